// File: doc/BRIEF.md
# Fabric Error Detect and Capture Unit

This unit sits beside an interconnect fabric and collects two kinds of error events. The first kind is a local access error: a transaction that matched no address window, or matched one whose target is invalid. The second kind is a coherency violation. Each event arrives as a one-cycle strobe with an 8-bit source ID, a 40-bit physical address and a 16-bit attribute word. The unit keeps one sticky detect bit per error kind. It takes a single snapshot of the first error that nobody has yet acknowledged, and it drives a level interrupt when an error that software has enabled is pending.

Software uses a simple 32-bit register bus with a write strobe and a combinational read port. A per-kind disable mask stops detection of that kind. A separate interrupt-enable mask only gates the interrupt. An interrupt handler reads the detect word, logs the snapshot and then writes the same detect word back. That write clears every bit it read as set, including the snapshot valid flag.

Top module: `err_capture_unit`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and `irq_o` is low.
- R2: A strobe on an error input whose disable bit is 0 sets its detect bit on the next clock edge. Local access errors use detect bit 0 and coherency violations use bit 1, at byte offset 0x00. The bit then stays set until software clears it.
- R3: The disable register is at offset 0x04 and uses the same bit positions, 0 and 1. While a bit is 1, strobes of that kind set no detect bit and take no snapshot. While it is 0, detection of that kind is active.
- R4: A detected error arriving while no snapshot is held loads the snapshot. The load sets bit 31 of offset 0x00 and writes the capture type into bits 30:26: 1 for a window miss, 2 for an invalid target, 3 for a coherency violation. The source ID goes to bits 25:18 of 0x0C. Address bits 39:32 go to bits 7:0 of 0x10 and address bits 31:0 go to 0x14. The attribute word goes to bits 15:0 of 0x18.
- R5: While the valid flag is 1, a further error sets its detect bit but leaves every snapshot field unchanged.
- R6: When both kinds are detected in the same cycle, both detect bits set and the snapshot records the local access error.
- R7: Writing 1 to bit 0, 1 or 31 of offset 0x00 clears that bit, and clearing bit 31 also clears the capture type. Writing 0 to a bit leaves it as it is. An error arriving in the same cycle as a clear wins: the bit stays set, and a new snapshot is loaded.
- R8: `irq_o` is high exactly when some detect bit in 1:0 is set and the matching bit of the interrupt-enable register (offset 0x08, bits 1:0) is 1. Clearing the enable lowers `irq_o` but leaves the detect bits.
- R9: Reads of unmapped offsets and of unused bits return zero. Writes to the snapshot registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lae_vld_i | input | 1 | Local access error strobe |
| lae_badtgt_i | input | 1 | With the strobe: 1 = invalid target, 0 = window miss |
| lae_src_i | input | 8 | Source ID of the local access error |
| lae_addr_i | input | 40 | Physical address of the local access error |
| lae_attr_i | input | 16 | Attributes of the local access error |
| cv_vld_i | input | 1 | Coherency violation strobe |
| cv_src_i | input | 8 | Source ID of the coherency violation |
| cv_addr_i | input | 40 | Physical address of the coherency violation |
| cv_attr_i | input | 16 | Attributes of the coherency violation |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Byte offset; bits 1:0 ignored |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| irq_o | output | 1 | Level interrupt |

## Verification
The properties assume that the error strobes and the bus write strobe are sampled only at rising edges and hold stable between them. They also assume that the write data always carries defined values. Nothing in the properties limits how often events may occur or whether both kinds may coincide. The bench changes every input only on falling edges and draws source IDs, addresses, attributes and write data at random. Strobe rates are kept modest, so that the valid flag is sometimes clear and sometimes set when an error arrives. Writes go to all offsets, including unmapped ones, so every protected field sees attempted corruption.

// File: rtl/errcap_pkg.sv
// errcap_pkg: widths, register offsets, field positions and capture codes
// shared by the error detect and capture unit. Assumes a 32-bit data bus
// and word-aligned registers.
package errcap_pkg;
    parameter int SRC_W   = 8;
    parameter int ADDR_W  = 40;
    parameter int ATTR_W  = 16;
    parameter int TYPE_W  = 5;
    parameter int NUM_EVT = 2;
    parameter int REG_AW  = 6;
    parameter int DATA_W  = 32;

    localparam int ADDRH_W = ADDR_W - 32;
    localparam int WORD_W  = REG_AW - 2;

    // word indices (byte offset >> 2)
    localparam logic [WORD_W-1:0] W_DET   = WORD_W'(0);
    localparam logic [WORD_W-1:0] W_DIS   = WORD_W'(1);
    localparam logic [WORD_W-1:0] W_INTEN = WORD_W'(2);
    localparam logic [WORD_W-1:0] W_CATTR = WORD_W'(3);
    localparam logic [WORD_W-1:0] W_CADRH = WORD_W'(4);
    localparam logic [WORD_W-1:0] W_CADRL = WORD_W'(5);
    localparam logic [WORD_W-1:0] W_CATR2 = WORD_W'(6);

    // field positions
    localparam int DET_VALID_BIT = 31;
    localparam int DET_TYPE_LSB  = 26;
    localparam int SRC_LSB       = 18;

    // capture type codes
    localparam logic [TYPE_W-1:0] CT_LAW_MISS = TYPE_W'(1);
    localparam logic [TYPE_W-1:0] CT_BAD_TGT  = TYPE_W'(2);
    localparam logic [TYPE_W-1:0] CT_COHER    = TYPE_W'(3);

    typedef struct packed {
        logic [TYPE_W-1:0] ctype;
        logic [SRC_W-1:0]  src;
        logic [ADDR_W-1:0] addr;
        logic [ATTR_W-1:0] attr;
    } snap_t;
endpackage

// File: rtl/errcap_detect.sv
// errcap_detect: one sticky detect bit per error kind plus the interrupt
// level. Assumes hit_i is already masked by the disable register; a set
// in the same cycle as a write-1 clear takes priority.
module errcap_detect
    import errcap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] hit_i,
    input  logic [NUM_EVT-1:0] clr_i,
    input  logic [NUM_EVT-1:0] inten_i,
    output logic [NUM_EVT-1:0] det_o,
    output logic               irq_o
);
    for (genvar g = 0; g < NUM_EVT; g++) begin : g_bit
        logic bit_q;
        // Sticky flag: set on hit, cleared by write-1, set wins.
        always_ff @(posedge clk) begin
            if (!rst_n)        bit_q <= 1'b0;
            else if (hit_i[g]) bit_q <= 1'b1;
            else if (clr_i[g]) bit_q <= 1'b0;
        end
        assign det_o[g] = bit_q;
    end

    // Interrupt level: any pending kind whose enable is set.
    always_comb irq_o = |(det_o & inten_i);
endmodule

// File: rtl/errcap_capture.sv
// errcap_capture: single snapshot of the first unacknowledged error.
// Assumes hit_i is masked; lower event index wins when several hit.
// Loads when empty or when software clears the valid flag that cycle.
module errcap_capture
    import errcap_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_EVT-1:0]        hit_i,
    input  logic                      badtgt_i,
    input  logic [NUM_EVT*SRC_W-1:0]  src_i,
    input  logic [NUM_EVT*ADDR_W-1:0] addr_i,
    input  logic [NUM_EVT*ATTR_W-1:0] attr_i,
    input  logic                      vclr_i,
    output snap_t                     snap_o,
    output logic                      valid_o
);
    snap_t sel;
    logic  load;

    function automatic logic [TYPE_W-1:0] code_of(input int idx, input logic bad);
        if (idx == 0) return bad ? CT_BAD_TGT : CT_LAW_MISS;
        return TYPE_W'(int'(CT_COHER) + idx - 1);
    endfunction

    // Priority pick: scan downward so the lowest hitting index remains.
    always_comb begin
        sel = '0;
        for (int i = NUM_EVT - 1; i >= 0; i--) begin
            if (hit_i[i]) begin
                sel.ctype = code_of(i, badtgt_i);
                sel.src   = src_i[i*SRC_W +: SRC_W];
                sel.addr  = addr_i[i*ADDR_W +: ADDR_W];
                sel.attr  = attr_i[i*ATTR_W +: ATTR_W];
            end
        end
    end

    // Load condition: an error and a free (or freeing) snapshot.
    always_comb load = (|hit_i) && (!valid_o || vclr_i);

    // Snapshot storage and valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            snap_o  <= '0;
        end else if (load) begin
            valid_o <= 1'b1;
            snap_o  <= sel;
        end else if (vclr_i) begin
            valid_o      <= 1'b0;
            snap_o.ctype <= '0;
        end
    end
endmodule

// File: rtl/errcap_regs.sv
// errcap_regs: register bus decode. Holds the disable and interrupt-enable
// masks, turns detect-word writes into write-1 clear pulses, and muxes
// read data. Assumes byte offsets with bits 1:0 ignored.
module errcap_regs
    import errcap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [REG_AW-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [NUM_EVT-1:0] det_i,
    input  logic               valid_i,
    input  snap_t              snap_i,
    output logic [NUM_EVT-1:0] dis_o,
    output logic [NUM_EVT-1:0] inten_o,
    output logic [NUM_EVT-1:0] clr_o,
    output logic               vclr_o,
    output logic [DATA_W-1:0]  rdata_o
);
    logic [WORD_W-1:0] word;
    logic              wr_det;

    // Word select from the byte offset.
    always_comb word = addr_i[REG_AW-1:2];

    // Write-1 clear pulses toward the detect bits and valid flag.
    always_comb begin
        wr_det = wr_i && (word == W_DET);
        clr_o  = wr_det ? wdata_i[NUM_EVT-1:0] : '0;
        vclr_o = wr_det && wdata_i[DET_VALID_BIT];
    end

    // Mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_o   <= '0;
            inten_o <= '0;
        end else if (wr_i) begin
            if (word == W_DIS)   dis_o   <= wdata_i[NUM_EVT-1:0];
            if (word == W_INTEN) inten_o <= wdata_i[NUM_EVT-1:0];
        end
    end

    // Read mux; unmapped words and unused bits return zero.
    always_comb begin
        rdata_o = '0;
        case (word)
            W_DET: begin
                rdata_o[NUM_EVT-1:0]                 = det_i;
                rdata_o[DET_TYPE_LSB +: TYPE_W]      = snap_i.ctype;
                rdata_o[DET_VALID_BIT]               = valid_i;
            end
            W_DIS:   rdata_o[NUM_EVT-1:0]            = dis_o;
            W_INTEN: rdata_o[NUM_EVT-1:0]            = inten_o;
            W_CATTR: rdata_o[SRC_LSB +: SRC_W]       = snap_i.src;
            W_CADRH: rdata_o[ADDRH_W-1:0]            = snap_i.addr[ADDR_W-1:32];
            W_CADRL: rdata_o                         = snap_i.addr[31:0];
            W_CATR2: rdata_o[ATTR_W-1:0]             = snap_i.attr;
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/err_capture_unit.sv
// err_capture_unit: fabric error detect and capture top. Masks the two
// error strobes with the disable register and feeds the detect bits, the
// snapshot and the register decode. Assumes one-cycle strobes.
module err_capture_unit
    import errcap_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lae_vld_i,
    input  logic                lae_badtgt_i,
    input  logic [SRC_W-1:0]    lae_src_i,
    input  logic [ADDR_W-1:0]   lae_addr_i,
    input  logic [ATTR_W-1:0]   lae_attr_i,
    input  logic                cv_vld_i,
    input  logic [SRC_W-1:0]    cv_src_i,
    input  logic [ADDR_W-1:0]   cv_addr_i,
    input  logic [ATTR_W-1:0]   cv_attr_i,
    input  logic                reg_wr_i,
    input  logic [REG_AW-1:0]   reg_addr_i,
    input  logic [DATA_W-1:0]   reg_wdata_i,
    output logic [DATA_W-1:0]   reg_rdata_o,
    output logic                irq_o
);
    logic [NUM_EVT-1:0] evt_vld, hit, det_w, dis_w, inten_w, clr_w;
    logic               vclr_w, cap_valid_w;
    snap_t              snap_w;

    // Event gating: disabled kinds never reach detect or capture.
    always_comb begin
        evt_vld = {cv_vld_i, lae_vld_i};
        hit     = evt_vld & ~dis_w;
    end

    errcap_detect u_det (
        .clk(clk), .rst_n(rst_n), .hit_i(hit), .clr_i(clr_w),
        .inten_i(inten_w), .det_o(det_w), .irq_o(irq_o)
    );

    errcap_capture u_cap (
        .clk(clk), .rst_n(rst_n), .hit_i(hit), .badtgt_i(lae_badtgt_i),
        .src_i({cv_src_i, lae_src_i}), .addr_i({cv_addr_i, lae_addr_i}),
        .attr_i({cv_attr_i, lae_attr_i}), .vclr_i(vclr_w),
        .snap_o(snap_w), .valid_o(cap_valid_w)
    );

    errcap_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .det_i(det_w), .valid_i(cap_valid_w),
        .snap_i(snap_w), .dis_o(dis_w), .inten_o(inten_w), .clr_o(clr_w),
        .vclr_o(vclr_w), .rdata_o(reg_rdata_o)
    );
endmodule

// File: rtl/errcap_chk.sv
// errcap_chk: temporal properties of the error capture unit, bound to the
// top. Assumes inputs change only between rising edges.
module errcap_chk
    import errcap_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               lae_vld_i,
    input logic               cv_vld_i,
    input logic               reg_wr_i,
    input logic [REG_AW-1:0]  reg_addr_i,
    input logic [DATA_W-1:0]  reg_wdata_i,
    input logic               irq_o,
    input logic [NUM_EVT-1:0] det_w,
    input logic [NUM_EVT-1:0] dis_w,
    input logic [NUM_EVT-1:0] inten_w,
    input logic               cap_valid_w,
    input snap_t              snap_w
);
    logic det_wr;
    always_comb det_wr = reg_wr_i && (reg_addr_i[REG_AW-1:2] == W_DET);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && !cap_valid_w && det_w == '0));

    // R2
    lae_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lae_vld_i && !dis_w[0]) |=> det_w[0]);

    // R3
    dis_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_w[0] && !det_w[0]) |=> !det_w[0]);

    // R4
    first_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_valid_w && ((lae_vld_i && !dis_w[0]) || (cv_vld_i && !dis_w[1])))
        |=> cap_valid_w);

    // R5
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid_w && !(det_wr && reg_wdata_i[DET_VALID_BIT])) |=> $stable(snap_w));

    // R7
    zero_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (det_w[1] && det_wr && !reg_wdata_i[1]) |=> det_w[1]);

    // R7
    one_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (det_w[0] && det_wr && reg_wdata_i[0] && !lae_vld_i) |=> !det_w[0]);

    // R8
    irq_needs_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (det_w != '0));

    // R8
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inten_w == '0) |-> !irq_o);
endmodule

bind err_capture_unit errcap_chk u_chk (
    .clk(clk), .rst_n(rst_n), .lae_vld_i(lae_vld_i), .cv_vld_i(cv_vld_i),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .irq_o(irq_o), .det_w(det_w), .dis_w(dis_w), .inten_w(inten_w),
    .cap_valid_w(cap_valid_w), .snap_w(snap_w)
);

// File: tb/sim_err_capture_unit.sv
`timescale 1ns/1ps
module sim_err_capture_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lae = 1'b0, bad = 1'b0, cv = 1'b0;
    logic [7:0]  lsrc = '0, csrc = '0;
    logic [39:0] laddr = '0, caddr = '0;
    logic [15:0] lattr = '0, cattr = '0;
    logic        wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // model state
    logic [1:0]  m_det = '0, m_dis = '0, m_inten = '0;
    logic        m_valid = 1'b0;
    logic [4:0]  m_type = '0;
    logic [7:0]  m_src = '0;
    logic [39:0] m_addr = '0;
    logic [15:0] m_attr = '0;

    always #2.5 clk = ~clk;

    err_capture_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .lae_vld_i(lae), .lae_badtgt_i(bad), .lae_src_i(lsrc),
        .lae_addr_i(laddr), .lae_attr_i(lattr),
        .cv_vld_i(cv), .cv_src_i(csrc), .cv_addr_i(caddr), .cv_attr_i(cattr),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [31:0] exp_read(input logic [5:0] a);
        case (a[5:2])
            4'd0: return {m_valid, m_type, 24'd0, m_det};
            4'd1: return {30'd0, m_dis};
            4'd2: return {30'd0, m_inten};
            4'd3: return {6'd0, m_src, 18'd0};
            4'd4: return {24'd0, m_addr[39:32]};
            4'd5: return m_addr[31:0];
            4'd6: return {16'd0, m_attr};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [5:0] a);
        case (a[5:2])
            4'd0: return "R2/R7";
            4'd1: return "R3";
            4'd2: return "R8";
            4'd3, 4'd4, 4'd5, 4'd6: return "R4/R5";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Next-state of the model from requirements R2..R8, applied at an edge.
    task automatic model_step();
        logic       h0, h1, clr31;
        logic [1:0] clr;
        h0 = lae & ~m_dis[0];
        h1 = cv & ~m_dis[1];
        clr = (wr && addr[5:2] == 4'd0) ? wdata[1:0] : 2'b00;
        clr31 = wr && addr[5:2] == 4'd0 && wdata[31];
        if ((h0 || h1) && (!m_valid || clr31)) begin
            m_valid = 1'b1;
            if (h0) begin
                m_type = bad ? 5'd2 : 5'd1;
                m_src = lsrc; m_addr = laddr; m_attr = lattr;
            end else begin
                m_type = 5'd3;
                m_src = csrc; m_addr = caddr; m_attr = cattr;
            end
        end else if (clr31) begin
            m_valid = 1'b0;
            m_type = '0;
        end
        m_det = {h1, h0} | (m_det & ~clr);
        if (wr && addr[5:2] == 4'd1) m_dis = wdata[1:0];
        if (wr && addr[5:2] == 4'd2) m_inten = wdata[1:0];
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic idle();
        lae = 0; cv = 0; bad = 0; wr = 0;
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
        wr = 1; addr = a; wdata = d;
        tick();
        wr = 0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a);
        addr = a;
        #1;
        chk(req, rdata, exp_read(a));
    endtask

    task automatic irq_chk(input string req);
        chk(req, {31'd0, irq}, {31'd0, |(m_det & m_inten)});
    endtask

    task automatic fire_lae(input logic b, input logic [7:0] s, input logic [39:0] ad, input logic [15:0] at);
        lae = 1; bad = b; lsrc = s; laddr = ad; lattr = at;
    endtask

    task automatic fire_cv(input logic [7:0] s, input logic [39:0] ad, input logic [15:0] at);
        cv = 1; csrc = s; caddr = ad; cattr = at;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: everything zero after reset
        for (int a = 0; a < 64; a += 4) rd_chk("R1", 6'(a));
        irq_chk("R1");

        // R2 R4 R8: first local access error, window miss
        wr_reg(6'h08, 32'h3);
        fire_lae(0, 8'hA5, 40'hAB_1234_5678, 16'hBEEF);
        tick(); idle();
        rd_chk("R2", 6'h00);
        chk("R4 type", rdata[30:26], 5'd1);
        rd_chk("R4 src", 6'h0C);
        rd_chk("R4 addrh", 6'h10);
        rd_chk("R4 addrl", 6'h14);
        rd_chk("R4 attr", 6'h18);
        chk("R8 irq", {31'd0, irq}, 32'd1);

        // R5: later coherency error does not overwrite
        fire_cv(8'h11, 40'h01_0000_0040, 16'h0042);
        tick(); idle();
        rd_chk("R5", 6'h00);
        chk("R5 det1", rdata[1:0], 2'b11);
        rd_chk("R5 addr", 6'h14);
        chk("R5 addrl kept", rdata, 32'h1234_5678);

        // R9: writes to snapshot registers ignored
        wr_reg(6'h14, 32'hFFFF_FFFF);
        wr_reg(6'h0C, 32'hFFFF_FFFF);
        rd_chk("R9 addrl", 6'h14);
        rd_chk("R9 src", 6'h0C);
        rd_chk("R9 unmapped", 6'h1C);
        rd_chk("R9 unmapped hi", 6'h3C);

        // R7: writing zeros has no effect, write-back clears all
        wr_reg(6'h00, 32'h0);
        rd_chk("R7 zeros", 6'h00);
        chk("R7 zeros kept", rdata, 32'h8400_0003);
        wr_reg(6'h00, 32'h8400_0003);
        rd_chk("R7 cleared", 6'h00);
        chk("R7 cleared zero", rdata, 32'h0);
        irq_chk("R8 after clear");

        // R6: both at once, invalid target wins snapshot
        fire_lae(1, 8'h22, 40'hC0_0000_1000, 16'h0001);
        fire_cv(8'h33, 40'h00_0000_2000, 16'h0002);
        tick(); idle();
        rd_chk("R6", 6'h00);
        chk("R6 word", rdata, 32'h8800_0003);
        rd_chk("R6 src", 6'h0C);

        // R7: error in the same cycle as a clear wins
        wr = 1; addr = 6'h00; wdata = 32'h8000_0003;
        fire_cv(8'h44, 40'h12_3456_789A, 16'h5555);
        tick(); idle();
        rd_chk("R7 set wins", 6'h00);
        chk("R7 set wins word", rdata, 32'h8C00_0002);
        rd_chk("R7 new snap", 6'h0C);
        wr_reg(6'h00, 32'h8000_0003);

        // R3: disabled kind ignored, other still active
        wr_reg(6'h04, 32'h1);
        fire_lae(0, 8'h55, 40'h1, 16'h1);
        tick(); idle();
        rd_chk("R3 blocked", 6'h00);
        chk("R3 blocked zero", rdata, 32'h0);
        fire_cv(8'h66, 40'h2, 16'h2);
        tick(); idle();
        rd_chk("R3 other active", 6'h00);
        wr_reg(6'h04, 32'h0);

        // R8: clearing enable drops irq, detect kept
        chk("R8 irq on", {31'd0, irq}, 32'd1);
        wr_reg(6'h08, 32'h0);
        irq_chk("R8 disabled");
        rd_chk("R8 det kept", 6'h00);
        wr_reg(6'h00, 32'h8000_0003);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            lae = ($urandom % 8) == 0;
            cv  = ($urandom % 8) == 0;
            bad = 1'($urandom);
            lsrc = 8'($urandom); csrc = 8'($urandom);
            laddr = {8'($urandom), $urandom()};
            caddr = {8'($urandom), $urandom()};
            lattr = 16'($urandom); cattr = 16'($urandom);
            wr = ($urandom % 4) == 0;
            addr = 6'($urandom);
            if (wr && addr[5:2] == 4'd0 && ($urandom % 2) == 0)
                wdata = exp_read(6'h00);
            else
                wdata = $urandom();
            tick();
            idle();
            begin
                logic [5:0] ra;
                ra = 6'($urandom);
                rd_chk(req_of(ra), ra);
            end
            irq_chk("R8");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule